// File: doc/BRIEF.md
# Writeback Scheduling Shift Queue

This block books future register-file writes for an issuing pipeline. Each instruction may ask for up to two writes, one in each of two independent columns. A request names a destination register, a write mask, a crossbar source port and a predicted latency. It is placed straight into the slot whose depth equals that latency, and is not appended at the tail. Every cycle, all slots move one step toward the head. The head slot drives the register-file write, and the slot behind it drives the crossbar select one cycle earlier.

The decoder uses the collision output to stall when the write it wants is already booked in that column at the same future cycle. A latency the queue cannot hold is rejected. A query port tells hazard logic whether any booked write in either column targets a given register.

Top module: `wb_sched_queue`

## Requirements
- R1: While reset is low (active-low `rstN`), and on the first cycle after it, every slot is empty: `wrEn`, `portVld` and `qHit` are all zero.
- R2: An accepted request with latency L (0 to DEPTH-1) sampled at clock edge E raises that column's `wrEn`, with the request's register and mask on `wrReg`/`wrMask`, for exactly the cycle that follows edge E+L. Before that cycle `wrEn` stays low.
- R3: The port selector of an accepted request appears on `portSel` with `portVld` high in the cycle before its write. For latency 0 it appears combinationally in the request cycle itself.
- R4: The two columns are independent. One instruction may book its two writes at different latencies, and each write leaves on its own column at its own time.
- R5: A request with latency of DEPTH or more raises `reject` for that column in the same cycle, and nothing is stored.
- R6: When the column already holds a write that will reach the same head cycle, `collide` rises in the request cycle. The booked entry is kept, and the new one is dropped.
- R7: `qHit` is high when any stored valid entry in either column targets `qReg`. A request offered in the current cycle does not count until the next cycle.
- R8: A collision is checked per column. The same latency in the other column does not collide.
- R9: After its write cycle an entry is gone. `wrEn` does not repeat it, and `qHit` no longer reports it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqVld | input | 2 | Per-column request strobe |
| reqReg | input | 2x6 | Destination register per column |
| reqMask | input | 2x2 | Write mask per column |
| reqPort | input | 2x4 | Crossbar source port per column |
| reqLat | input | 2x4 | Predicted latency per column (0 = head) |
| qReg | input | 6 | Register number to look up |
| collide | output | 2 | Per-column: requested cycle already booked |
| reject | output | 2 | Per-column: latency out of range |
| wrEn | output | 2 | Per-column register-file write enable |
| wrReg | output | 2x6 | Per-column write address |
| wrMask | output | 2x2 | Per-column write mask |
| portVld | output | 2 | Per-column crossbar select valid |
| portSel | output | 2x4 | Per-column crossbar port select |
| qHit | output | 1 | Some booked write targets `qReg` |

## Verification
Insertion and shifting meet in the same cycle. A new request is written into the slot that the next entry would otherwise shift into. The bench provokes this by booking a write and then, one cycle later, asking for one latency less in the same column. It expects `collide` and the original register at the head on time. In the same cycle, the other column asks for that latency and must be accepted and written alongside. A latency-0 booking on the cycle after another one also checks that the crossbar bypass and the shifted slot-1 entry never drive `portSel` together.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int REG_BITS  = 6;
  localparam int MASK_BITS = 2;
  localparam int PORT_BITS = 4;
  localparam int LAT_BITS  = 4;
  localparam int NCOL      = 2;

  typedef struct packed {
    logic                 vld;
    logic [REG_BITS-1:0]  dst;
    logic [MASK_BITS-1:0] mask;
    logic [PORT_BITS-1:0] port;
  } slot_t;

  typedef struct packed {
    logic                load;
    logic [LAT_BITS-1:0] idx;
    logic                bypass;
  } colStrobe_t;
endpackage

// File: rtl/wbq_ctrl.sv
module wbq_ctrl
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NCOL-1:0]                      reqVld,
  input  logic [NCOL-1:0][LAT_BITS-1:0]        reqLat,
  input  logic [NCOL-1:0][DEPTH-1:0]           occVec,
  output colStrobe_t [NCOL-1:0]                strobe,
  output logic [NCOL-1:0]                      collide,
  output logic [NCOL-1:0]                      reject
);
  localparam logic [LAT_BITS:0] DEPTH_L = (LAT_BITS+1)'(DEPTH);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic inRange;
    logic busy;

    assign inRange = {1'b0, reqLat[c]} < DEPTH_L;

    // slot L is next fed by slot L+1; a valid entry there owns that cycle
    always_comb begin
      busy = 1'b0;
      for (int k = 0; k < DEPTH-1; k++) begin
        if (reqLat[c] == LAT_BITS'(k)) busy = occVec[c][k+1];
      end
    end

    assign reject[c]        = reqVld[c] && !inRange;
    assign collide[c]       = reqVld[c] && inRange && busy;
    assign strobe[c].load   = reqVld[c] && inRange && !busy;
    assign strobe[c].idx    = reqLat[c];
    assign strobe[c].bypass = reqVld[c] && inRange && !busy && (reqLat[c] == '0);

    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
      (reqVld[c] && ({1'b0, reqLat[c]} >= DEPTH_L)) |-> (reject[c] && !strobe[c].load)); // R5
    AST_COLLIDE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      collide[c] |-> (!strobe[c].load && !reject[c])); // R6
  end
endmodule

// File: rtl/wbq_slots.sv
module wbq_slots
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  colStrobe_t [NCOL-1:0]                strobe,
  input  logic [NCOL-1:0][REG_BITS-1:0]        reqReg,
  input  logic [NCOL-1:0][MASK_BITS-1:0]       reqMask,
  input  logic [NCOL-1:0][PORT_BITS-1:0]       reqPort,
  input  logic [REG_BITS-1:0]                  qReg,
  output logic [NCOL-1:0][DEPTH-1:0]           occVec,
  output logic [NCOL-1:0]                      wrEn,
  output logic [NCOL-1:0][REG_BITS-1:0]        wrReg,
  output logic [NCOL-1:0][MASK_BITS-1:0]       wrMask,
  output logic [NCOL-1:0]                      portVld,
  output logic [NCOL-1:0][PORT_BITS-1:0]       portSel,
  output logic                                 qHit
);
  slot_t q [NCOL][DEPTH];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    slot_t newEntry;
    assign newEntry = '{vld: 1'b1, dst: reqReg[c], mask: reqMask[c], port: reqPort[c]};

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      slot_t nxt;
      always_comb begin
        if (k == DEPTH-1) nxt = '0;
        else              nxt = q[c][(k == DEPTH-1) ? k : k+1];
        if (strobe[c].load && strobe[c].idx == LAT_BITS'(k)) nxt = newEntry;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q[c][k] <= '0;
        else       q[c][k] <= nxt;
      end

      assign occVec[c][k] = q[c][k].vld;

      AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[c].load && strobe[c].idx == LAT_BITS'(k))
          |=> (q[c][k].vld && q[c][k].dst == $past(reqReg[c]))); // R2
    end

    assign wrEn[c]    = q[c][0].vld;
    assign wrReg[c]   = q[c][0].dst;
    assign wrMask[c]  = q[c][0].mask;
    assign portVld[c] = q[c][1].vld | strobe[c].bypass;
    assign portSel[c] = strobe[c].bypass ? reqPort[c] : q[c][1].port;

    AST_PORT_LEADS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      portVld[c] |=> wrEn[c]); // R3
    AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe[c].bypass && q[c][1].vld)); // R6
    AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
      q[c][1].vld |=> (wrEn[c] && wrReg[c] == $past(q[c][1].dst))); // R2
    AST_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[c] && !q[c][1].vld && !strobe[c].bypass) |=> !wrEn[c]); // R9
  end

  always_comb begin
    qHit = 1'b0;
    for (int c = 0; c < NCOL; c++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (q[c][k].vld && q[c][k].dst == qReg) qHit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wb_sched_queue.sv
module wb_sched_queue
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NCOL-1:0]                      reqVld,
  input  logic [NCOL-1:0][REG_BITS-1:0]        reqReg,
  input  logic [NCOL-1:0][MASK_BITS-1:0]       reqMask,
  input  logic [NCOL-1:0][PORT_BITS-1:0]       reqPort,
  input  logic [NCOL-1:0][LAT_BITS-1:0]        reqLat,
  input  logic [REG_BITS-1:0]                  qReg,
  output logic [NCOL-1:0]                      collide,
  output logic [NCOL-1:0]                      reject,
  output logic [NCOL-1:0]                      wrEn,
  output logic [NCOL-1:0][REG_BITS-1:0]        wrReg,
  output logic [NCOL-1:0][MASK_BITS-1:0]       wrMask,
  output logic [NCOL-1:0]                      portVld,
  output logic [NCOL-1:0][PORT_BITS-1:0]       portSel,
  output logic                                 qHit
);
  colStrobe_t [NCOL-1:0]      strobe;
  logic [NCOL-1:0][DEPTH-1:0] occVec;

  wbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqVld  (reqVld),
    .reqLat  (reqLat),
    .occVec  (occVec),
    .strobe  (strobe),
    .collide (collide),
    .reject  (reject)
  );

  wbq_slots #(.DEPTH(DEPTH)) u_slots (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqReg  (reqReg),
    .reqMask (reqMask),
    .reqPort (reqPort),
    .qReg    (qReg),
    .occVec  (occVec),
    .wrEn    (wrEn),
    .wrReg   (wrReg),
    .wrMask  (wrMask),
    .portVld (portVld),
    .portSel (portSel),
    .qHit    (qHit)
  );
endmodule

// File: tb/sim_wb_sched_queue.sv
`timescale 1ns/1ps
module sim_wb_sched_queue;
  import wbq_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]       reqVld;
  logic [1:0][5:0]  reqReg;
  logic [1:0][1:0]  reqMask;
  logic [1:0][3:0]  reqPort;
  logic [1:0][3:0]  reqLat;
  logic [5:0]       qReg;
  logic [1:0]       collide, reject, wrEn, portVld;
  logic [1:0][5:0]  wrReg;
  logic [1:0][1:0]  wrMask;
  logic [1:0][3:0]  portSel;
  logic             qHit;

  int nVec = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  wb_sched_queue #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .reqVld(reqVld), .reqReg(reqReg), .reqMask(reqMask),
    .reqPort(reqPort), .reqLat(reqLat), .qReg(qReg), .collide(collide),
    .reject(reject), .wrEn(wrEn), .wrReg(wrReg), .wrMask(wrMask),
    .portVld(portVld), .portSel(portSel), .qHit(qHit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    reqVld = '0; reqReg = '0; reqMask = '0; reqPort = '0; reqLat = '0;
  endtask

  task automatic post(input int c, input int lat, input int rg, input int mk, input int pt);
    reqVld[c]  = 1'b1;
    reqLat[c]  = 4'(lat);
    reqReg[c]  = 6'(rg);
    reqMask[c] = 2'(mk);
    reqPort[c] = 4'(pt);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 wrEn", 32'(wrEn), 0);
    chk("R1 portVld", 32'(portVld), 0);
    chk("R1 qHit", 32'(qHit), 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 wrEn after release", 32'(wrEn), 0);
  endtask

  task automatic t_single(input int c, input int lat, input int rg, input int mk, input int pt);
    @(negedge clk);
    post(c, lat, rg, mk, pt);
    qReg = 6'(rg);
    #1;
    chk("R5 no reject", 32'(reject[c]), 0);
    chk("R6 no collide", 32'(collide[c]), 0);
    chk("R7 same-cycle query", 32'(qHit), 0);
    if (lat == 0) begin
      chk("R3 bypass vld", 32'(portVld[c]), 1);
      chk("R3 bypass sel", 32'(portSel[c]), 32'(pt));
    end
    @(negedge clk);
    idle();
    #1;
    chk("R7 booked hit", 32'(qHit), 1);
    for (int i = 1; i <= lat + 1; i++) begin
      int pos;
      if (i > 1) begin @(negedge clk); #1; end
      pos = lat - (i - 1);
      if (pos == 1) begin
        chk("R3 port vld", 32'(portVld[c]), 1);
        chk("R3 port sel", 32'(portSel[c]), 32'(pt));
      end
      if (pos == 0) begin
        chk("R2 wrEn", 32'(wrEn[c]), 1);
        chk("R2 wrReg", 32'(wrReg[c]), 32'(rg));
        chk("R2 wrMask", 32'(wrMask[c]), 32'(mk));
      end else begin
        chk("R2 early wrEn", 32'(wrEn[c]), 0);
      end
    end
    @(negedge clk); #1;
    chk("R9 retired wrEn", 32'(wrEn), 0);
    chk("R9 retired qHit", 32'(qHit), 0);
  endtask

  task automatic t_dual();
    @(negedge clk);
    post(0, 2, 10, 1, 3);
    post(1, 5, 11, 2, 9);
    @(negedge clk);
    idle();
    for (int n = 1; n <= 7; n++) begin
      logic [1:0] exp;
      if (n > 1) @(negedge clk);
      #1;
      exp = {n == 6, n == 3};
      chk("R4 wrEn pattern", 32'(wrEn), 32'(exp));
      if (n == 3) chk("R4 col0 reg", 32'(wrReg[0]), 10);
      if (n == 6) chk("R4 col1 reg", 32'(wrReg[1]), 11);
    end
  endtask

  task automatic t_reject();
    @(negedge clk);
    post(0, 8, 40, 1, 1);
    post(1, 15, 40, 1, 1);
    qReg = 6'd40;
    #1;
    chk("R5 reject both", 32'(reject), 3);
    chk("R5 no collide", 32'(collide), 0);
    @(negedge clk);
    idle();
    for (int n = 0; n < 10; n++) begin
      #1;
      chk("R5 nothing written", 32'(wrEn), 0);
      chk("R5 nothing booked", 32'(qHit), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_collide();
    @(negedge clk);
    post(0, 4, 20, 1, 5);
    @(negedge clk);
    idle();
    post(0, 3, 21, 2, 6);
    post(1, 3, 22, 3, 7);
    #1;
    chk("R6 collide col0 R8 none col1", 32'(collide), 1);
    @(negedge clk);
    idle();
    qReg = 6'd21;
    #1;
    chk("R6 dropped entry absent", 32'(qHit), 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 R8 both write", 32'(wrEn), 3);
    chk("R6 kept reg", 32'(wrReg[0]), 20);
    chk("R8 col1 reg", 32'(wrReg[1]), 22);
    @(negedge clk); #1;
    chk("R9 drained", 32'(wrEn), 0);
  endtask

  task automatic t_bypass_after();
    // latency 1 then latency 0 next cycle must collide (same head cycle)
    @(negedge clk);
    post(1, 1, 50, 1, 12);
    @(negedge clk);
    idle();
    post(1, 0, 51, 2, 13);
    #1;
    chk("R6 lat0 behind lat1", 32'(collide[1]), 1);
    chk("R3 slot1 port kept", 32'(portSel[1]), 12);
    @(negedge clk);
    idle();
    #1;
    chk("R2 lat1 written", 32'(wrReg[1]), 50);
    @(negedge clk); #1;
    chk("R9 empty", 32'(wrEn), 0);
  endtask

  initial begin
    idle();
    qReg = '0;
    t_reset();
    t_single(0, 0, 1, 1, 2);
    t_single(0, 3, 5, 2, 4);
    t_single(1, 7, 63, 3, 15);
    t_single(1, 1, 9, 0, 8);
    t_dual();
    t_reject();
    t_collide();
    t_bypass_after();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule